// File: doc/BRIEF.md
# Buffered-Access 16-Bit Timer

This block is a 16-bit up-counter that hangs off an 8-bit register bus with four addresses. Software programs a control byte, reads and writes the counter one byte at a time, and polls a sticky wrap flag. A prescaler sits in front of the counter. Its input is either every system clock or a synchronous strobe from a secondary source. The prescaler advances only while the control byte enables counting and the `count_gate` input is high.

When the buffered mode is on, the upper counter byte is reached only through a shadow register. A read of the low byte captures the live upper byte into the shadow in the same cycle, so a following read of the upper address returns a value that matches the low byte already fetched. A write goes the other way: the upper byte is staged in the shadow first, and a write of the low byte then commits both halves on one edge. With the mode off, both bytes are read and written in place.

Top module: `tmr16_timer`

## Requirements
- R1: Address map: 0 control, 1 counter low byte, 2 counter high byte, 3 status. Read data is combinational from `bus_addr`. With control bit 7 clear, addresses 1 and 2 read and write the live counter bytes directly.
- R2: With control bit 7 set, a read of address 1 returns the live low byte, and on that edge the live high byte is copied into the shadow.
- R3: With control bit 7 set, a read of address 2 returns the shadow contents, not the live high byte.
- R4: With control bit 7 set, a write of address 2 loads only the shadow and leaves the live counter untouched.
- R5: With control bit 7 set, a write of address 1 loads the live low byte from the bus data and the live high byte from the shadow on the same edge.
- R6: A write of address 1 clears the prescaler. A write of address 2 never clears it.
- R7: Control bit 3 set makes `ext_tick` high cycles the count source; clear makes every clock a source cycle. A source cycle reaches the prescaler only when control bit 0 and `count_gate` are both high.
- R8: Control bits 5:4 select a prescale ratio of 1, 2, 4 or 8 (values 0 to 3). The counter advances once per that many qualified source cycles.
- R9: A wrap from 0xFFFF to 0x0000 sets status bit 0 (also driven on `ovf_flag`). Writing status with bit 0 = 0 clears it. A wrap on the same edge as a clearing write leaves it set.
- R10: When a write to the counter (low byte in either mode, high byte in direct mode) falls on the same edge as an increment, the written value is kept and the increment is lost.
- R11: Reset clears the counter, shadow, prescaler, control and status. The control byte reads back bits 7, 5, 4, 3 and 0, with the other bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_tick | input | 1 | Secondary count source, one strobe per high cycle |
| count_gate | input | 1 | Count enable qualifier |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
Access is tried with interleaved shadow writes, low-byte reads and upper reads, and with a mode switch back to direct access. This separates the shadow from the live upper byte, which would otherwise look the same. Counting is driven by the free-running clock at ratios 1 and 4, by sparse secondary strobes at ratios 2 and 8, and with the gate or the strobe held low, so that each ratio and each source qualifier gives a different count. Counter writes, clearing writes and prescaler-only writes are placed on the same edge as an increment. This tells the priority rules apart from an ordinary increment, and shows which writes reset the prescaler phase.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_LO   = 2'd1,
    ADR_HI   = 2'd2,
    ADR_STAT = 2'd3
  } addr_e;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_EXT  = 3;
  localparam int unsigned CB_PS   = 4;
  localparam int unsigned CB_BUF  = 7;
  localparam int unsigned PS_SEL_W = 2;

  typedef struct packed {
    logic                buf_mode;
    logic [PS_SEL_W-1:0] ps_sel;
    logic                ext_src;
    logic                run;
  } ctrl_t;

endpackage

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pulse,
  input  logic [SEL_W-1:0] sel,
  output logic             tick,
  output logic [(1<<SEL_W)-2:0] phase
);
  localparam int unsigned PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    for (int i = 0; i < PC_W; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  assign tick = pulse && ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (pulse) begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign phase = cnt_q;
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int unsigned BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [1:0]         ld_en,
  input  logic [2*BUS_W-1:0] ld_val,
  input  logic               ovf_clr,
  output logic [2*BUS_W-1:0] count,
  output logic               ovf
);
  localparam int unsigned CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, loaded;
  logic             ovf_q, ovf_d, wrap;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign loaded[g*BUS_W +: BUS_W] = ld_en[g] ? ld_val[g*BUS_W +: BUS_W]
                                               : cnt_q[g*BUS_W +: BUS_W];
  end

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (|ld_en) begin
      cnt_d = loaded;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = &cnt_q;
    end
  end

  always_comb begin
    ovf_d = ovf_q;
    if (wrap)         ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [1:0]         addr,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [2*BUS_W-1:0] count,
  input  logic               ovf,
  output ctrl_t              ctrl,
  output logic [BUS_W-1:0]   hbuf,
  output logic [1:0]         ld_en,
  output logic [2*BUS_W-1:0] ld_val,
  output logic               presc_clr,
  output logic               ovf_clr,
  output logic [BUS_W-1:0]   rdata
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [BUS_W-1:0] hbuf_q, hbuf_d;
  logic             wr_ctrl, wr_lo, wr_hi, wr_stat, rd_lo;
  logic [BUS_W-1:0] ctrl_rd;

  assign wr_ctrl = wr && (addr == ADR_CTRL);
  assign wr_lo   = wr && (addr == ADR_LO);
  assign wr_hi   = wr && (addr == ADR_HI);
  assign wr_stat = wr && (addr == ADR_STAT);
  assign rd_lo   = rd && (addr == ADR_LO);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.buf_mode = wdata[CB_BUF];
      ctrl_d.ps_sel   = wdata[CB_PS +: PS_SEL_W];
      ctrl_d.ext_src  = wdata[CB_EXT];
      ctrl_d.run      = wdata[CB_RUN];
    end
  end

  always_comb begin
    hbuf_d = hbuf_q;
    if (ctrl_q.buf_mode) begin
      if (wr_hi)      hbuf_d = wdata;
      else if (rd_lo) hbuf_d = count[2*BUS_W-1:BUS_W];
    end
  end

  always_comb begin
    ld_en = 2'b00;
    if (wr_lo)                         ld_en = ctrl_q.buf_mode ? 2'b11 : 2'b01;
    else if (wr_hi && !ctrl_q.buf_mode) ld_en = 2'b10;
  end

  assign ld_val    = {(ctrl_q.buf_mode ? hbuf_q : wdata), wdata};
  assign presc_clr = wr_lo;
  assign ovf_clr   = wr_stat && !wdata[0];

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_BUF]            = ctrl_q.buf_mode;
    ctrl_rd[CB_PS +: PS_SEL_W] = ctrl_q.ps_sel;
    ctrl_rd[CB_EXT]            = ctrl_q.ext_src;
    ctrl_rd[CB_RUN]            = ctrl_q.run;
  end

  always_comb begin
    unique case (addr)
      ADR_CTRL: rdata = ctrl_rd;
      ADR_LO:   rdata = count[BUS_W-1:0];
      ADR_HI:   rdata = ctrl_q.buf_mode ? hbuf_q : count[2*BUS_W-1:BUS_W];
      default:  rdata = {{(BUS_W-1){1'b0}}, ovf};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hbuf_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      hbuf_q <= hbuf_d;
    end
  end

  assign ctrl = ctrl_q;
  assign hbuf = hbuf_q;
endmodule

// File: rtl/tmr16_timer.sv
module tmr16_timer
  import tmr16_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ext_tick,
  input  logic             count_gate,
  output logic             ovf_flag
);
  localparam int unsigned CNT_W = 2 * BUS_W;
  localparam int unsigned PH_W  = (1 << PS_SEL_W) - 1;

  logic [1:0]       rst_sync;
  logic             rst_q;
  ctrl_t            ctrl;
  logic [BUS_W-1:0] hbuf;
  logic [1:0]       ld_en;
  logic [CNT_W-1:0] ld_val, count;
  logic             presc_clr, ovf_clr, ovf, pulse, tick;
  logic [PH_W-1:0]  phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign pulse = ctrl.run && count_gate && (ctrl.ext_src ? ext_tick : 1'b1);

  tmr16_regs #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .ovf(ovf), .ctrl(ctrl), .hbuf(hbuf),
    .ld_en(ld_en), .ld_val(ld_val), .presc_clr(presc_clr), .ovf_clr(ovf_clr),
    .rdata(bus_rdata)
  );

  tmr16_presc #(.SEL_W(PS_SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_q), .clr(presc_clr), .pulse(pulse),
    .sel(ctrl.ps_sel), .tick(tick), .phase(phase)
  );

  tmr16_core #(.BUS_W(BUS_W)) u_core (
    .clk(clk), .rst_n(rst_q), .tick(tick), .ld_en(ld_en), .ld_val(ld_val),
    .ovf_clr(ovf_clr), .count(count), .ovf(ovf)
  );

  assign ovf_flag = ovf;
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker #(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned PH_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               buf_mode,
  input logic               wr,
  input logic               rd,
  input logic [1:0]         addr,
  input logic [BUS_W-1:0]   wdata,
  input logic [2*BUS_W-1:0] count,
  input logic [BUS_W-1:0]   hbuf,
  input logic               tick,
  input logic               ovf,
  input logic [PH_W-1:0]    phase
);
  logic wr_lo, wr_hi, rd_lo, cnt_write, stat_clr;
  assign wr_lo     = wr && (addr == 2'd1);
  assign wr_hi     = wr && (addr == 2'd2);
  assign rd_lo     = rd && (addr == 2'd1);
  assign cnt_write = wr_lo || (wr_hi && !buf_mode);
  assign stat_clr  = wr && (addr == 2'd3) && !wdata[0];

  p_snap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && rd_lo && !wr_hi) |=> (hbuf == $past(count[2*BUS_W-1:BUS_W])));

  p_hwr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && wr_hi && !tick) |=> (count == $past(count)));

  p_hwr_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && wr_hi) |=> (hbuf == $past(wdata)));

  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && wr_lo) |=> (count == {$past(hbuf), $past(wdata)}));

  p_pclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (phase == '0));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&count) && !cnt_write) |=> (ovf && (count == '0)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !stat_clr) |=> ovf);

  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !buf_mode) |=> (count[BUS_W-1:0] == $past(wdata)));
endmodule

bind tmr16_timer tmr16_checker #(.BUS_W(BUS_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .buf_mode(ctrl.buf_mode), .wr(bus_wr),
  .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata), .count(count),
  .hbuf(hbuf), .tick(tick), .ovf(ovf), .phase(phase)
);

// File: tb/tmr16_timer_test.sv
`timescale 1ns/1ps
module tmr16_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_tick = 1'b0, count_gate = 1'b0;
  logic       ovf_flag;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  tmr16_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .count_gate(count_gate), .ovf_flag(ovf_flag)
  );

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a; ext_tick = 1'b0;
    it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic t);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d; ext_tick = t;
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_rd = 1'b0; ext_tick = t;
    end
  endtask

  task automatic set16(input logic [7:0] h, input logic [7:0] l);
    wr(2'd2, h, 1'b0);
    wr(2'd1, l, 1'b0);
  endtask

  // monitor: pops expected items as reads are presented
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard underflow: read with no expectation (got %02h)", bus_rdata);
      end else begin
        item_t it;
        it = q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4, 1'b0);

    // R11 reset state
    rd(2'd0, 8'h00, "R11 ctrl reset");
    rd(2'd1, 8'h00, "R11 low reset");
    rd(2'd2, 8'h00, "R11 high reset");
    rd(2'd3, 8'h00, "R11 status reset");
    wr(2'd0, 8'hFF, 1'b0);
    rd(2'd0, 8'hB9, "R11 ctrl readback mask");
    wr(2'd0, 8'h00, 1'b0);

    // R1 direct access
    set16(8'h12, 8'h34);
    rd(2'd1, 8'h34, "R1 direct low");
    rd(2'd2, 8'h12, "R1 direct high");

    // buffered access
    wr(2'd0, 8'h80, 1'b0);
    wr(2'd2, 8'hAB, 1'b0);
    rd(2'd2, 8'hAB, "R3 high read gives shadow");
    rd(2'd1, 8'h34, "R2 buffered low read live");
    rd(2'd2, 8'h12, "R4 live high kept, R2 snapshot");
    wr(2'd2, 8'h56, 1'b0);
    wr(2'd1, 8'h78, 1'b0);
    rd(2'd1, 8'h78, "R5 commit low");
    rd(2'd2, 8'h56, "R5 commit high");
    wr(2'd2, 8'h99, 1'b0);
    rd(2'd2, 8'h99, "R3 shadow not live");
    wr(2'd0, 8'h00, 1'b0);
    rd(2'd2, 8'h56, "R4 live high after shadow write");

    // R8 ratio 1, internal clock: 10 qualified cycles
    count_gate = 1'b1;
    set16(8'h00, 8'h00);
    wr(2'd0, 8'h01, 1'b0);
    idle(9, 1'b0);
    wr(2'd0, 8'h00, 1'b0);
    rd(2'd1, 8'h0A, "R8 ratio 1 count");

    // R8 ratio 4: 10 cycles -> 2
    set16(8'h00, 8'h00);
    wr(2'd0, 8'h21, 1'b0);
    idle(9, 1'b0);
    wr(2'd0, 8'h00, 1'b0);
    rd(2'd1, 8'h02, "R8 ratio 4 count");

    // R7 gate low blocks counting
    set16(8'h00, 8'h00);
    count_gate = 1'b0;
    wr(2'd0, 8'h01, 1'b0);
    idle(10, 1'b0);
    wr(2'd0, 8'h00, 1'b0);
    rd(2'd1, 8'h00, "R7 gate low holds count");
    count_gate = 1'b1;

    // R7 external source: no strobes, then 5 strobes
    wr(2'd0, 8'h09, 1'b0);
    idle(10, 1'b0);
    rd(2'd1, 8'h00, "R7 ext source idle");
    for (int i = 0; i < 5; i++) begin
      idle(1, 1'b1);
      idle(2, 1'b0);
    end
    rd(2'd1, 8'h05, "R7 five ext strobes");

    // R8 ratio 8 with ext strobes
    wr(2'd0, 8'h39, 1'b0);
    set16(8'h00, 8'h00);
    for (int i = 0; i < 8; i++) begin
      idle(1, 1'b1);
      idle(1, 1'b0);
    end
    rd(2'd1, 8'h01, "R8 ratio 8 count");

    // R9 overflow
    wr(2'd0, 8'h09, 1'b0);
    set16(8'hFF, 8'hFE);
    idle(1, 1'b1);
    idle(1, 1'b1);
    idle(1, 1'b0);
    rd(2'd3, 8'h01, "R9 flag set on wrap");
    rd(2'd1, 8'h00, "R9 low after wrap");
    rd(2'd2, 8'h00, "R9 high after wrap");
    idle(3, 1'b0);
    rd(2'd3, 8'h01, "R9 flag sticky");
    wr(2'd3, 8'h00, 1'b0);
    rd(2'd3, 8'h00, "R9 flag cleared");
    set16(8'hFF, 8'hFF);
    wr(2'd3, 8'h00, 1'b1);
    rd(2'd3, 8'h01, "R9 wrap wins over clear");
    rd(2'd1, 8'h00, "R9 count wrapped");
    wr(2'd3, 8'h00, 1'b0);

    // R10 write beats increment
    set16(8'h00, 8'h00);
    wr(2'd1, 8'h40, 1'b1);
    rd(2'd1, 8'h40, "R10 low write drops increment");
    wr(2'd2, 8'h05, 1'b1);
    rd(2'd1, 8'h40, "R10 high write drops increment low");
    rd(2'd2, 8'h05, "R10 high write value");

    // R6 prescaler clearing, ratio 2
    wr(2'd0, 8'h19, 1'b0);
    set16(8'h00, 8'h00);
    idle(1, 1'b1);
    wr(2'd2, 8'h00, 1'b0);
    idle(1, 1'b1);
    rd(2'd1, 8'h01, "R6 high write keeps prescaler");
    idle(1, 1'b1);
    wr(2'd1, 8'h00, 1'b0);
    idle(1, 1'b1);
    rd(2'd1, 8'h00, "R6 low write clears prescaler");

    idle(3, 1'b0);
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: %0d reads not seen, actual %0d expected 0", q.size(), q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule